// File: doc/BRIEF.md
# Erased Sector Screen

This block runs after the ECC decoder has given up on a sector. It decides whether the sector is really a freshly erased one that has only a few flipped bits. An erased sector reads back as all ones in both its payload and its stored check bytes. Because the check code of an all-ones payload is not itself all ones, the decoder reports far more errors than it can correct. The block watches the same byte stream the decoder consumed, one byte per cycle, and counts the bits that read as zero. It keeps one tally for payload bytes and one for check bytes, and each tally stops growing once it passes the correction limit.

On the closing byte of a sector the block looks at the decoder's error count presented alongside that byte. If that count does not exceed the limit, the decoder already handled the sector and the screen reports nothing. Otherwise the two tallies are added. A sum within the limit marks the sector as erased and reports the sum as the number of flips repaired. A larger sum marks the sector as uncorrectable. When an erased sector had zeros in its payload, a separate flag tells the surrounding logic to overwrite the payload with all ones. The block does not perform that overwrite itself.

Top module: `erased_sector_check`

## Requirements
- R1: After reset, res_valid, res_erased, res_uncorr and res_fill_ones are 0 and res_flips is 0.
- R2: res_valid is high for exactly the one cycle that follows a beat with in_valid=1 and in_last=1, and is low in every other cycle.
- R3: The verdict applies only when dec_errs, sampled on the closing beat, is greater than LIMIT (8). Otherwise res_erased, res_uncorr and res_fill_ones are 0 and res_flips is 0.
- R4: The zeros of each accepted byte are counted as the number of 0 bits in it. A byte with in_is_ecc=0 adds to the payload tally and a byte with in_is_ecc=1 adds to the check tally.
- R5: Each tally is capped at LIMIT+1 (9). When the verdict applies, res_flips equals the sum of the two tallies capped at LIMIT+1.
- R6: When the verdict applies and the tally sum is at most LIMIT, res_erased=1 and res_flips equals that sum.
- R7: When the verdict applies and the tally sum exceeds LIMIT, res_uncorr=1 and res_erased=0. res_erased and res_uncorr are never both 1.
- R8: res_fill_ones is 1 exactly when res_erased is 1 and the payload tally is nonzero. Zeros found only in check bytes leave it 0.
- R9: A beat with in_valid=1 and in_first=1 clears both tallies before its own byte is counted. Beats with in_valid=0 change nothing, whatever in_byte, in_first and in_last carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A stream byte is present this cycle |
| in_byte | input | BYTE_W (8) | Stream byte |
| in_is_ecc | input | 1 | 1 = check byte, 0 = payload byte |
| in_first | input | 1 | Opening beat of a sector |
| in_last | input | 1 | Closing beat of a sector |
| dec_errs | input | ERR_W (4) | Error count reported by the decoder, sampled on the closing beat |
| res_valid | output | 1 | One-cycle pulse: verdict outputs updated |
| res_erased | output | 1 | Sector treated as erased |
| res_uncorr | output | 1 | Sector is uncorrectable |
| res_fill_ones | output | 1 | Payload must be overwritten with all ones |
| res_flips | output | CNT_W (4) | Repaired flip count (capped sum) |

## Verification
Every verdict output is due in the cycle right after the closing beat. A single register stage sits between the closing byte and the outputs, and the tallies feed that stage through their next-state values, so the closing byte itself is included. The bench drives beats on the falling edge and reads the verdict on the first falling edge after the closing beat. It then checks on the following falling edge that res_valid has dropped while the verdict values hold. Expected results come from the bench's own zero count over the stored sector image.

// File: rtl/esc_pkg.sv
package esc_pkg;
  // Stream tag carried by in_is_ecc
  typedef enum logic {
    TAG_PAYLOAD = 1'b0,
    TAG_CHECK   = 1'b1
  } esc_tag_e;

  // Number of tallies kept, indexed by tag value
  localparam int unsigned NUM_TALLY = 2;
endpackage

// File: rtl/esc_zero_count.sv
module esc_zero_count #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned PC_W  = $clog2(BYTE_W + 1)
) (
  input  logic [BYTE_W-1:0] byte_i,
  output logic [PC_W-1:0]   zeros_o
);
  logic [BYTE_W-1:0] inv;

  genvar g;
  generate
    for (g = 0; g < BYTE_W; g++) begin : g_inv
      assign inv[g] = ~byte_i[g];
    end
  endgenerate

  always_comb begin
    zeros_o = '0;
    for (int i = 0; i < BYTE_W; i++) begin
      zeros_o = zeros_o + PC_W'(inv[i]);
    end
  end
endmodule

// File: rtl/esc_tally.sv
module esc_tally #(
  parameter int unsigned LIMIT = 8,
  parameter int unsigned PC_W  = 4,
  localparam int unsigned CNT_W = $clog2(LIMIT + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat_i,
  input  logic             clr_i,
  input  logic             add_en_i,
  input  logic [PC_W-1:0]  add_i,
  output logic [CNT_W-1:0] cnt_q_o,
  output logic [CNT_W-1:0] cnt_d_o
);
  localparam logic [CNT_W-1:0] CAP  = CNT_W'(LIMIT + 1);
  localparam int unsigned      WIDE = (CNT_W > PC_W ? CNT_W : PC_W) + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] base;
  logic [WIDE-1:0]  wide_sum;
  logic [CNT_W-1:0] cnt_d;

  // next-state
  always_comb begin
    base     = clr_i ? '0 : cnt_q;
    wide_sum = WIDE'(base) + WIDE'(add_i);
    if (!add_en_i) begin
      cnt_d = base;
    end else if (wide_sum > WIDE'(CAP)) begin
      cnt_d = CAP;
    end else begin
      cnt_d = CNT_W'(wide_sum);
    end
  end

  // register with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (beat_i) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_q_o = cnt_q;
  assign cnt_d_o = cnt_d;

  AST_TALLY_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CAP); // R5
  AST_TALLY_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_i |=> $stable(cnt_q)); // R9
  AST_TALLY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_i && clr_i && !add_en_i) |=> (cnt_q == '0)); // R9
endmodule

// File: rtl/esc_verdict.sv
module esc_verdict #(
  parameter int unsigned LIMIT = 8,
  parameter int unsigned ERR_W = 4,
  localparam int unsigned CNT_W = $clog2(LIMIT + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             close_i,
  input  logic [ERR_W-1:0] dec_errs_i,
  input  logic [CNT_W-1:0] pay_cnt_i,
  input  logic [CNT_W-1:0] chk_cnt_i,
  output logic             res_valid_o,
  output logic             res_erased_o,
  output logic             res_uncorr_o,
  output logic             res_fill_o,
  output logic [CNT_W-1:0] res_flips_o
);
  localparam int unsigned      SUM_W     = CNT_W + 1;
  localparam logic [SUM_W-1:0] SUM_LIMIT = SUM_W'(LIMIT);
  localparam logic [SUM_W-1:0] SUM_CAP   = SUM_W'(LIMIT + 1);
  localparam logic [CNT_W-1:0] CAP       = CNT_W'(LIMIT + 1);

  logic [SUM_W-1:0] sum;
  logic             trig;
  logic             erased_d, uncorr_d, fill_d;
  logic [CNT_W-1:0] flips_d;

  logic             valid_q, erased_q, uncorr_q, fill_q;
  logic [CNT_W-1:0] flips_q;

  // next-state
  always_comb begin
    sum      = SUM_W'(pay_cnt_i) + SUM_W'(chk_cnt_i);
    trig     = ({{(32-ERR_W){1'b0}}, dec_errs_i} > 32'(LIMIT));
    erased_d = trig && (sum <= SUM_LIMIT);
    uncorr_d = trig && (sum >  SUM_LIMIT);
    fill_d   = erased_d && (pay_cnt_i != '0);
    if (!trig) begin
      flips_d = '0;
    end else if (sum > SUM_CAP) begin
      flips_d = CAP;
    end else begin
      flips_d = CNT_W'(sum);
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= close_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      erased_q <= 1'b0;
      uncorr_q <= 1'b0;
      fill_q   <= 1'b0;
      flips_q  <= '0;
    end else if (close_i) begin
      erased_q <= erased_d;
      uncorr_q <= uncorr_d;
      fill_q   <= fill_d;
      flips_q  <= flips_d;
    end
  end

  assign res_valid_o  = valid_q;
  assign res_erased_o = erased_q;
  assign res_uncorr_o = uncorr_q;
  assign res_fill_o   = fill_q;
  assign res_flips_o  = flips_q;

  AST_VALID_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    close_i |=> valid_q); // R2
  AST_VALID_ONLY_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    !close_i |=> !valid_q); // R2
  AST_VERDICT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(erased_q && uncorr_q)); // R7
  AST_FILL_NEEDS_ERASED: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q |-> erased_q); // R8
  AST_FLIPS_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    flips_q <= CAP); // R5
  AST_QUIET_BELOW_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    (close_i && !trig) |=> (!erased_q && !uncorr_q && flips_q == '0)); // R3
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !close_i |=> ($stable(erased_q) && $stable(flips_q))); // R2
endmodule

// File: rtl/erased_sector_check.sv
module erased_sector_check #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned LIMIT  = 8,
  parameter int unsigned ERR_W  = 4,
  localparam int unsigned CNT_W = $clog2(LIMIT + 2),
  localparam int unsigned PC_W  = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              in_is_ecc,
  input  logic              in_first,
  input  logic              in_last,
  input  logic [ERR_W-1:0]  dec_errs,
  output logic              res_valid,
  output logic              res_erased,
  output logic              res_uncorr,
  output logic              res_fill_ones,
  output logic [CNT_W-1:0]  res_flips
);
  import esc_pkg::*;

  logic [PC_W-1:0]  zeros;
  logic             clr;
  logic             close;
  esc_tag_e         tag;
  logic [CNT_W-1:0] cnt_q [NUM_TALLY];
  logic [CNT_W-1:0] cnt_d [NUM_TALLY];

  assign tag   = esc_tag_e'(in_is_ecc);
  assign clr   = in_valid && in_first;
  assign close = in_valid && in_last;

  esc_zero_count #(.BYTE_W(BYTE_W)) i_zero_count (
    .byte_i  (in_byte),
    .zeros_o (zeros)
  );

  genvar t;
  generate
    for (t = 0; t < NUM_TALLY; t++) begin : g_tally
      logic add_en;
      assign add_en = in_valid && (tag == esc_tag_e'(t));
      esc_tally #(.LIMIT(LIMIT), .PC_W(PC_W)) i_tally (
        .clk      (clk),
        .rst_n    (rst_n),
        .beat_i   (in_valid),
        .clr_i    (clr),
        .add_en_i (add_en),
        .add_i    (zeros),
        .cnt_q_o  (cnt_q[t]),
        .cnt_d_o  (cnt_d[t])
      );
    end
  endgenerate

  esc_verdict #(.LIMIT(LIMIT), .ERR_W(ERR_W)) i_verdict (
    .clk          (clk),
    .rst_n        (rst_n),
    .close_i      (close),
    .dec_errs_i   (dec_errs),
    .pay_cnt_i    (cnt_d[TAG_PAYLOAD]),
    .chk_cnt_i    (cnt_d[TAG_CHECK]),
    .res_valid_o  (res_valid),
    .res_erased_o (res_erased),
    .res_uncorr_o (res_uncorr),
    .res_fill_o   (res_fill_ones),
    .res_flips_o  (res_flips)
  );

  AST_CHECK_TALLY_STILL_ON_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_first && !in_is_ecc) |=> $stable(cnt_q[TAG_CHECK])); // R4
  AST_PAYLOAD_TALLY_STILL_ON_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_first && in_is_ecc) |=> $stable(cnt_q[TAG_PAYLOAD])); // R4
endmodule

// File: tb/test_erased_sector_check.sv
module test_erased_sector_check;
  localparam int NPAY = 512;
  localparam int NCHK = 13;
  localparam int NTOT = NPAY + NCHK;
  localparam int LIM  = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_is_ecc, in_first, in_last;
  logic [7:0] in_byte;
  logic [3:0] dec_errs;
  logic       res_valid, res_erased, res_uncorr, res_fill_ones;
  logic [3:0] res_flips;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;
  logic [7:0] sec [NTOT];

  always #4 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  erased_sector_check i_erased_sector_check (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_is_ecc(in_is_ecc), .in_first(in_first), .in_last(in_last),
    .dec_errs(dec_errs), .res_valid(res_valid), .res_erased(res_erased),
    .res_uncorr(res_uncorr), .res_fill_ones(res_fill_ones), .res_flips(res_flips)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int zeros_in(input logic [7:0] b);
    int z = 0;
    for (int i = 0; i < 8; i++) if (!b[i]) z++;
    return z;
  endfunction

  function automatic int min9(input int v);
    return (v > LIM + 1) ? LIM + 1 : v;
  endfunction

  task automatic idle();
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    in_is_ecc = 1'b0; in_byte = 8'h00;
  endtask

  task automatic fill_ones();
    for (int i = 0; i < NTOT; i++) sec[i] = 8'hFF;
  endtask

  task automatic flip(input int n);
    for (int k = 0; k < n; k++) sec[$urandom % NTOT][$urandom % 8] = 1'b0;
  endtask

  // Streams sec[], optionally with bubbles carrying junk, then checks the verdict
  task automatic run_sector(input int errs, input bit bubbles, input string tag);
    int dz = 0, ez = 0, sum, eflip;
    bit trig, er, un, fl;
    for (int i = 0; i < NTOT; i++) begin
      if (i < NPAY) dz += zeros_in(sec[i]); else ez += zeros_in(sec[i]);
      if (bubbles && ($urandom % 4 == 0)) begin
        in_valid = 1'b0; in_byte = 8'h00; in_first = 1'b1; in_last = 1'b1;
        in_is_ecc = $urandom % 2; dec_errs = 4'd15;
        @(negedge clk);
        // R9: a bubble with in_last set must not produce a result
        chk("R9", {tag, " bubble valid"}, int'(res_valid), 0);
      end
      in_valid  = 1'b1;
      in_byte   = sec[i];
      in_is_ecc = (i >= NPAY);
      in_first  = (i == 0);
      in_last   = (i == NTOT - 1);
      dec_errs  = (i == NTOT - 1) ? 4'(errs) : 4'($urandom % 16);
      @(negedge clk);
    end
    idle();
    sum   = min9(dz) + min9(ez);
    trig  = errs > LIM;
    er    = trig && sum <= LIM;
    un    = trig && sum > LIM;
    fl    = er && dz != 0;
    eflip = trig ? min9(sum) : 0;
    chk("R2", {tag, " valid"}, int'(res_valid), 1);
    chk(trig ? "R6" : "R3", {tag, " erased"}, int'(res_erased), int'(er));
    chk(trig ? "R7" : "R3", {tag, " uncorr"}, int'(res_uncorr), int'(un));
    chk("R8", {tag, " fill"}, int'(res_fill_ones), int'(fl));
    chk("R5", {tag, " flips"}, int'(res_flips), eflip);
    @(negedge clk);
    chk("R2", {tag, " valid drop"}, int'(res_valid), 0);
    chk("R2", {tag, " flips hold"}, int'(res_flips), eflip);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    rst_n = 1'b0; dec_errs = 4'd0;
    idle();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "valid", int'(res_valid), 0);
    chk("R1", "erased", int'(res_erased), 0);
    chk("R1", "uncorr", int'(res_uncorr), 0);
    chk("R1", "fill", int'(res_fill_ones), 0);
    chk("R1", "flips", int'(res_flips), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6: clean erased sector
    fill_ones(); run_sector(15, 0, "all-ones");
    // R6 R8: exactly LIMIT payload zeros
    fill_ones(); for (int i = 0; i < 8; i++) sec[i * 50][i] = 1'b0;
    run_sector(12, 0, "eight-payload");
    // R7: one over the limit
    fill_ones(); for (int i = 0; i < 9; i++) sec[i * 40][0] = 1'b0;
    run_sector(9, 0, "nine-payload");
    // R8: zeros only in check bytes leave fill low
    fill_ones(); sec[NPAY][2] = 1'b0; sec[NPAY + 5][7] = 1'b0; sec[NTOT - 1][0] = 1'b0;
    run_sector(10, 0, "check-only");
    // R4 R7: split across tallies, 5 + 4 = 9
    fill_ones(); sec[3] = 8'hE0; sec[NPAY + 1] = 8'hF0;
    run_sector(9, 0, "split-nine");
    // R3: decoder count at limit, no verdict
    fill_ones(); sec[7][3] = 1'b0;
    run_sector(8, 0, "below-trigger");
    // R5: heavy zeros saturate
    for (int i = 0; i < NTOT; i++) sec[i] = 8'h00;
    run_sector(15, 0, "all-zero");
    // R9: aborted partial sector full of zeros, then a fresh start clears
    for (int i = 0; i < 100; i++) begin
      in_valid = 1'b1; in_byte = 8'h00; in_is_ecc = 1'b0;
      in_first = (i == 0); in_last = 1'b0; @(negedge clk);
    end
    fill_ones(); sec[9][1] = 1'b0;
    run_sector(13, 0, "restart");
    // random sectors, with bubbles
    for (int s = 0; s < 30; s++) begin
      int errs;
      fill_ones();
      if (s % 5 == 4) for (int i = 0; i < NTOT; i++) sec[i] = 8'($urandom);
      else flip($urandom % 13);
      errs = ($urandom % 4 == 0) ? $urandom % 9 : 9 + $urandom % 7;
      run_sector(errs, s % 2, "random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule